// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a byte-wide parallel NOR flash bus. It runs three kinds of embedded operation: programming a single byte, erasing one 64 KB sector, and erasing the whole array. A client offers a request made of an operation code, a 19-bit byte address and a data byte. The request is taken through a valid/ready handshake, and only while the sequencer is idle.

Once a request is taken, the sequencer drives the unlock write cycles that the flash expects, each one at a fixed address and data pattern. The width of the write-enable low pulse and the high gap between pulses come from clock-cycle parameters. After the last write it reads the status byte again and again, with a set number of idle cycles between reads. It stops when bit 7 shows the true value again, because the flash returns the inverted bit 7 while it is still busy. A cycle limit on the polling phase turns a stuck operation into an error. Every request ends with a single-cycle done pulse, and the error flag is valid in that same cycle.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, req_ready_o is 1, done_o and err_o are 0, flash_ce_no, flash_we_no and flash_oe_no are 1, and flash_dq_oe_o is 0.
- R2: A request is taken on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o then stays 0 until the operation ends. done_o is high for exactly one cycle, and req_ready_o is 1 in that cycle.
- R3: Operation code 0 (byte program) issues exactly four write cycles, in this order: 0xAA to 0x05555, 0x55 to 0x02AAA, 0xA0 to 0x05555, then the request data to the request address.
- R4: Operation code 1 (sector erase) issues exactly six writes: 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, then 0x30 to the request address. Bits 18:16 of that address pick one of 8 sectors.
- R5: Operation code 2 (chip erase) issues the same first five writes as R4, then writes 0x10 to 0x05555.
- R6: Each write-enable low pulse lasts exactly WE_LOW_CYC clock cycles. Between two pulses, flash_we_no stays high for at least WE_HIGH_CYC cycles.
- R7: While flash_we_no is low, the address and write data hold steady, flash_dq_oe_o is 1 and flash_oe_no is 1. A write enable and an output enable are never low at the same time.
- R8: Status reads drive flash_oe_no and flash_ce_no low, with flash_we_no high and flash_dq_oe_o low. The operation ends without error on the first read whose bit 7 equals the expected value, so a flash that stays busy for N reads sees exactly N+1 reads. The expected bit is bit 7 of the request data for a program and 1 for either erase.
- R9: If polling has lasted TIMEOUT_CYC cycles and the latest read still shows busy, the sequencer ends the operation with err_o = 1 together with done_o.
- R10: Operation code 3 is reserved. It is taken and answered with done_o and err_o in the next cycle, and no bus cycle is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr_i | input | ADDR_W | Target byte address |
| req_data_i | input | 8 | Byte to program |
| done_o | output | 1 | Single-cycle completion pulse |
| err_o | output | 1 | Error, valid with done_o |
| flash_addr_o | output | ADDR_W | Flash address bus |
| flash_dq_o | output | 8 | Flash write data |
| flash_dq_oe_o | output | 1 | Enable for the write data driver |
| flash_dq_i | input | 8 | Flash read data |
| flash_ce_no | output | 1 | Flash chip enable, active low |
| flash_we_no | output | 1 | Flash write enable, active low |
| flash_oe_no | output | 1 | Flash output enable, active low |

## Verification
The properties assume a clean request interface, meaning req_op_i and the other request fields are known whenever req_valid_i is high. They also assume the flash holds flash_dq_i steady for the whole of a status read. The bench drives request fields only at falling clock edges. Its flash model changes its read value only when the output enable rises, so every sample falls inside a stable window. The bench sweeps data patterns, busy lengths, all eight sectors, the reserved code and a flash that never finishes.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    B_IDLE,
    B_WLOW,
    B_WHIGH,
    B_READ
  } bus_st_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_POLL,
    S_PWAIT,
    S_GAP
  } seq_st_e;

  localparam logic [15:0] UNLOCK_A = 16'h5555;
  localparam logic [15:0] UNLOCK_B = 16'h2AAA;
endpackage

// File: rtl/ncs_seq_table.sv
module ncs_seq_table
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  op_e                 op_i,
  input  logic [STEP_W-1:0]   step_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                last_o
);
  localparam logic [ADDR_W-1:0] UA = ADDR_W'(UNLOCK_A);
  localparam logic [ADDR_W-1:0] UB = ADDR_W'(UNLOCK_B);

  always_comb begin
    addr_o = UA;
    data_o = 8'hAA;
    last_o = 1'b0;
    if (op_i == OP_PROG) begin
      case (step_i)
        3'd0: begin addr_o = UA; data_o = 8'hAA; end
        3'd1: begin addr_o = UB; data_o = 8'h55; end
        3'd2: begin addr_o = UA; data_o = 8'hA0; end
        default: begin addr_o = addr_i; data_o = data_i; last_o = 1'b1; end
      endcase
    end else begin
      case (step_i)
        3'd0: begin addr_o = UA; data_o = 8'hAA; end
        3'd1: begin addr_o = UB; data_o = 8'h55; end
        3'd2: begin addr_o = UA; data_o = 8'h80; end
        3'd3: begin addr_o = UA; data_o = 8'hAA; end
        3'd4: begin addr_o = UB; data_o = 8'h55; end
        default: begin
          last_o = 1'b1;
          if (op_i == OP_CHIP) begin
            addr_o = UA;
            data_o = 8'h10;
          end else begin
            addr_o = addr_i;
            data_o = 8'h30;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ncs_bus_cycle.sv
module ncs_bus_cycle
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int WE_LOW_CYC  = 5,
  parameter int WE_HIGH_CYC = 4,
  parameter int RD_CYC      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic              flash_dq_oe_o,
  input  logic [DATA_W-1:0] flash_dq_i,
  output logic              flash_ce_no,
  output logic              flash_we_no,
  output logic              flash_oe_no
);
  localparam int MAX_A = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int MAX_C = (MAX_A > RD_CYC) ? MAX_A : RD_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] LO_LAST = CW'(WE_LOW_CYC - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(WE_HIGH_CYC - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);

  bus_st_e           st_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= B_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        B_IDLE: if (start_i) begin
          st_q   <= write_i ? B_WLOW : B_READ;
          cnt_q  <= '0;
          addr_q <= addr_i;
          data_q <= wdata_i;
        end
        B_WLOW: if (cnt_q == LO_LAST) begin
          st_q  <= B_WHIGH;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        B_WHIGH: if (cnt_q == HI_LAST) st_q <= B_IDLE;
                 else cnt_q <= cnt_q + 1'b1;
        B_READ: if (cnt_q == RD_LAST) st_q <= B_IDLE;
                else cnt_q <= cnt_q + 1'b1;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign done_o        = ((st_q == B_WHIGH) && (cnt_q == HI_LAST)) ||
                         ((st_q == B_READ) && (cnt_q == RD_LAST));
  assign rdata_o       = flash_dq_i;
  assign flash_addr_o  = addr_q;
  assign flash_dq_o    = data_q;
  assign flash_dq_oe_o = (st_q == B_WLOW) || (st_q == B_WHIGH);
  assign flash_ce_no   = (st_q == B_IDLE);
  assign flash_we_no   = (st_q != B_WLOW);
  assign flash_oe_no   = (st_q != B_READ);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int WE_LOW_CYC   = 5,
  parameter int WE_HIGH_CYC  = 4,
  parameter int RD_CYC       = 10,
  parameter int POLL_GAP_CYC = 4,
  parameter int TIMEOUT_CYC  = 1_500_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [7:0]        flash_dq_o,
  output logic              flash_dq_oe_o,
  input  logic [7:0]        flash_dq_i,
  output logic              flash_ce_no,
  output logic              flash_we_no,
  output logic              flash_oe_no
);
  localparam int TW = $clog2(TIMEOUT_CYC + 2);
  localparam int GW = $clog2(POLL_GAP_CYC + 2);
  localparam logic [TW-1:0] TMO_LIM  = TW'(TIMEOUT_CYC);
  localparam logic [GW-1:0] GAP_LAST = GW'(POLL_GAP_CYC);

  seq_st_e           st_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STEP_W-1:0] step_q;
  logic [TW-1:0]     tmo_q;
  logic [GW-1:0]     gap_q;
  logic              done_q, err_q;

  logic              bus_start, bus_write, bus_done;
  logic [DATA_W-1:0] bus_rdata;
  logic [ADDR_W-1:0] tbl_addr;
  logic [DATA_W-1:0] tbl_data;
  logic              tbl_last;
  logic              exp_bit7;
  logic              accept;

  ncs_seq_table #(.ADDR_W(ADDR_W)) u_table (
    .op_i   (op_q),
    .step_i (step_q),
    .addr_i (addr_q),
    .data_i (data_q),
    .addr_o (tbl_addr),
    .data_o (tbl_data),
    .last_o (tbl_last)
  );

  ncs_bus_cycle #(
    .ADDR_W      (ADDR_W),
    .WE_LOW_CYC  (WE_LOW_CYC),
    .WE_HIGH_CYC (WE_HIGH_CYC),
    .RD_CYC      (RD_CYC)
  ) u_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (bus_start),
    .write_i       (bus_write),
    .addr_i        (tbl_addr),
    .wdata_i       (tbl_data),
    .done_o        (bus_done),
    .rdata_o       (bus_rdata),
    .flash_addr_o  (flash_addr_o),
    .flash_dq_o    (flash_dq_o),
    .flash_dq_oe_o (flash_dq_oe_o),
    .flash_dq_i    (flash_dq_i),
    .flash_ce_no   (flash_ce_no),
    .flash_we_no   (flash_we_no),
    .flash_oe_no   (flash_oe_no)
  );

  assign req_ready_o = (st_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign bus_start   = (st_q == S_ISSUE) || (st_q == S_POLL);
  assign bus_write   = (st_q == S_ISSUE);
  // erase leaves the array at all ones
  assign exp_bit7    = (op_q == OP_PROG) ? data_q[7] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      step_q <= '0;
      tmo_q  <= '0;
      gap_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if ((st_q == S_POLL || st_q == S_PWAIT || st_q == S_GAP) && tmo_q < TMO_LIM)
        tmo_q <= tmo_q + 1'b1;
      case (st_q)
        S_IDLE: if (accept) begin
          if (op_e'(req_op_i) == OP_RSVD) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            op_q   <= op_e'(req_op_i);
            addr_q <= req_addr_i;
            data_q <= req_data_i;
            step_q <= '0;
            st_q   <= S_ISSUE;
          end
        end
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT: if (bus_done) begin
          if (tbl_last) begin
            st_q  <= S_POLL;
            tmo_q <= '0;
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= S_ISSUE;
          end
        end
        S_POLL: st_q <= S_PWAIT;
        S_PWAIT: if (bus_done) begin
          if (bus_rdata[7] == exp_bit7) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (tmo_q >= TMO_LIM) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            gap_q <= '0;
            st_q  <= S_GAP;
          end
        end
        S_GAP: if (gap_q >= GAP_LAST - 1'b1) st_q <= S_POLL;
               else gap_q <= gap_q + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int ADDR_W     = 19,
  parameter int WE_LOW_CYC = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic [7:0]        flash_dq_o,
  input logic              flash_dq_oe_o,
  input logic              flash_ce_no,
  input logic              flash_we_no,
  input logic              flash_oe_no
);
  logic [15:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_run <= '0;
    else if (!flash_we_no) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  assert_no_bus_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (flash_we_no && flash_oe_no && flash_ce_no && !flash_dq_oe_o));

  assert_done_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_we_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_we_no) |-> (low_run == 16'(WE_LOW_CYC)));

  assert_we_oe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!flash_we_no && !flash_oe_no));

  assert_drive_on_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_no |-> (flash_dq_oe_o && !flash_ce_no));

  assert_stable_on_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && $past(!flash_we_no)) |-> ($stable(flash_addr_o) && $stable(flash_dq_o)));

  assert_read_no_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_no |-> (!flash_dq_oe_o && flash_we_no && !flash_ce_no));

  assert_err_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
  .ADDR_W     (ADDR_W),
  .WE_LOW_CYC (WE_LOW_CYC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .flash_addr_o  (flash_addr_o),
  .flash_dq_o    (flash_dq_o),
  .flash_dq_oe_o (flash_dq_oe_o),
  .flash_ce_no   (flash_ce_no),
  .flash_we_no   (flash_we_no),
  .flash_oe_no   (flash_oe_no)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 19;
  localparam int WLO  = 3;
  localparam int WHI  = 2;
  localparam int RDC  = 2;
  localparam int GAP  = 2;
  localparam int TMO  = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          done, err;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_dq_o, f_dq_i;
  logic          f_dq_oe, f_ce_n, f_we_n, f_oe_n;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  int wr_n = 0, rd_n = 0, wr_base = 0, rd_base = 0;
  int busy_reads = 0;
  logic exp7 = 1'b1;
  logic [AW-1:0] wr_addr [64];
  logic [7:0]    wr_data [64];
  int lo_run = 0, hi_run = 0;
  logic in_op = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq #(
    .ADDR_W(AW), .WE_LOW_CYC(WLO), .WE_HIGH_CYC(WHI), .RD_CYC(RDC),
    .POLL_GAP_CYC(GAP), .TIMEOUT_CYC(TMO)
  ) u_nor_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .done_o(done), .err_o(err),
    .flash_addr_o(f_addr), .flash_dq_o(f_dq_o), .flash_dq_oe_o(f_dq_oe),
    .flash_dq_i(f_dq_i), .flash_ce_no(f_ce_n), .flash_we_no(f_we_n),
    .flash_oe_no(f_oe_n)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // flash model: busy reads return inverted bit 7
  assign f_dq_i = ((rd_n - rd_base) < busy_reads) ? {~exp7, 7'h00} : {exp7, 7'h7F};

  always @(posedge f_oe_n) if (rst_n) rd_n++;

  always @(posedge f_we_n) if (rst_n) begin
    wr_addr[wr_n & 63] = f_addr;
    wr_data[wr_n & 63] = f_dq_o;
    chk(lo_run == WLO, "R6 we low width", lo_run, WLO);
    chk(f_oe_n && f_dq_oe, "R7 oe high and dq driven at strobe", {f_oe_n, f_dq_oe}, 2'b11);
    wr_n++;
  end

  always @(negedge clk) begin
    if (!f_we_n) begin
      if (in_op && (wr_n - wr_base) > 0)
        chk(hi_run >= WHI || lo_run > 0, "R6 we high gap", hi_run, WHI);
      lo_run++;
      hi_run = 0;
    end else begin
      lo_run = 0;
      hi_run++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic void exp_write(input logic [1:0] op, input int i,
                                    input logic [AW-1:0] a, input logic [7:0] d,
                                    output logic [AW-1:0] ea, output logic [7:0] ed);
    logic [AW-1:0] pa [6];
    logic [7:0]    pd [6];
    pa[0] = 19'h05555; pd[0] = 8'hAA;
    pa[1] = 19'h02AAA; pd[1] = 8'h55;
    if (op == 2'd0) begin
      pa[2] = 19'h05555; pd[2] = 8'hA0;
      pa[3] = a;         pd[3] = d;
      pa[4] = '0; pd[4] = '0; pa[5] = '0; pd[5] = '0;
    end else begin
      pa[2] = 19'h05555; pd[2] = 8'h80;
      pa[3] = 19'h05555; pd[3] = 8'hAA;
      pa[4] = 19'h02AAA; pd[4] = 8'h55;
      pa[5] = (op == 2'd2) ? 19'h05555 : a;
      pd[5] = (op == 2'd2) ? 8'h10 : 8'h30;
    end
    ea = pa[i];
    ed = pd[i];
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [7:0] d, input int busy, input string tag);
    int lat;
    int nw;
    logic e;
    logic [AW-1:0] ea;
    logic [7:0] ed;
    nw = (op == 2'd0) ? 4 : ((op == 2'd3) ? 0 : 6);
    wr_base = wr_n;
    rd_base = rd_n;
    busy_reads = busy;
    exp7 = (op == 2'd0) ? d[7] : 1'b1;
    in_op = 1'b1;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_op = 2'd0; req_addr = '0; req_data = '0;
    if (op != 2'd3) chk(!req_ready && !done, {tag, " R2 ready low while busy"}, req_ready, 0);
    lat = 0;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    e = err;
    chk(done && req_ready, {tag, " R2 done with ready"}, {done, req_ready}, 2'b11);
    @(negedge clk);
    chk(!done && req_ready, {tag, " R2 done one cycle"}, done, 0);
    in_op = 1'b0;
    chk((wr_n - wr_base) == nw, {tag, " R3/R4/R5 write count"}, wr_n - wr_base, nw);
    for (int i = 0; i < nw && i < (wr_n - wr_base); i++) begin
      exp_write(op, i, a, d, ea, ed);
      chk(wr_addr[(wr_base + i) & 63] == ea, {tag, " R3 R4 R5 write addr"}, wr_addr[(wr_base + i) & 63], ea);
      chk(wr_data[(wr_base + i) & 63] == ed, {tag, " R3 R4 R5 write data"}, wr_data[(wr_base + i) & 63], ed);
    end
    if (op == 2'd3) begin
      chk(e == 1'b1 && lat == 0, {tag, " R10 reserved answered at once with error"}, {e, lat[3:0]}, 5'h10);
      chk(rd_n == rd_base, {tag, " R10 no reads"}, rd_n - rd_base, 0);
    end else if (busy > 1000) begin
      chk(e == 1'b1, {tag, " R9 timeout error"}, e, 1);
      chk((rd_n - rd_base) >= 1, {tag, " R9 polled before timeout"}, rd_n - rd_base, 1);
    end else begin
      chk(e == 1'b0, {tag, " R8 no error"}, e, 0);
      chk((rd_n - rd_base) == busy + 1, {tag, " R8 read count"}, rd_n - rd_base, busy + 1);
    end
  endtask

  initial begin
    logic [7:0] pats [5];
    pats[0] = 8'h00; pats[1] = 8'h7F; pats[2] = 8'h80; pats[3] = 8'hFF; pats[4] = 8'h5A;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !err, "R1 reset handshake", {req_ready, done, err}, 3'b100);
    chk(f_we_n && f_oe_n && f_ce_n && !f_dq_oe, "R1 reset bus idle",
        {f_we_n, f_oe_n, f_ce_n, f_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && f_we_n && f_oe_n && f_ce_n, "R1 idle after reset",
        {req_ready, f_we_n, f_oe_n, f_ce_n}, 4'hF);

    for (int p = 0; p < 5; p++)
      for (int b = 0; b < 4; b++)
        run_op(2'd0, AW'(19'h1_2345 + p * 19'h1_1111 + b), pats[p], b, "R3 program");

    for (int s = 0; s < 8; s++)
      run_op(2'd1, {s[2:0], 16'h0ABC ^ 16'(s * 16'h1357)}, 8'h00, s % 3, "R4 sector erase");

    run_op(2'd2, 19'h7_FFFF, 8'h00, 0, "R5 chip erase");
    run_op(2'd2, 19'h0_0000, 8'h12, 3, "R5 chip erase");

    run_op(2'd3, 19'h0_1234, 8'h55, 0, "R10 reserved");

    run_op(2'd0, 19'h3_0001, 8'h80, 100000, "R9 timeout program");
    run_op(2'd1, 19'h5_0000, 8'h00, 100000, "R9 timeout erase");

    run_op(2'd0, 19'h0_0010, 8'h01, 1, "R8 after timeout");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule